// File: doc/BRIEF.md
# Circular Audio Buffer Pointer Tracker

This block follows the producer and consumer positions inside a circular audio buffer held in memory, for one playback or one capture stream. Software programs the buffer's first address, its end address (one past the last byte), a period size and an interrupt threshold through a small register port. It then starts the stream in one of two directions, and each side advances its own pointer by a byte count. The occupancy figures are always on the outputs: bytes waiting to be consumed, free bytes, and the contiguous part of each that runs before the physical end of the buffer.

The buffer is never allowed to fill completely. The free figure always holds back an 8-byte gap, so a full buffer can be told apart from an empty one. Pointers can be parked in staging registers and committed later by a separate load strobe. A snapshot strobe freezes either live pointer, as an absolute address, for later reading. One level interrupt line collects four sticky status bits, and software clears each bit by writing a one to it. Two of the bits are threshold events: free space reaching the threshold, used for playback, and waiting data reaching it, used for capture. The other two flag overrun requests.

Write register map (reg_addr): 0 buffer start, 1 buffer end, 2 threshold, 3 period, 4 read-pointer staging, 5 write-pointer staging, 6 load strobe (bit0 read, bit1 write), 7 snapshot strobe (bit0 read, bit1 write), 8 start (bit0: 0 playback, 1 capture), 9 clear (write one to clear). Read map (reg_raddr): 0 start, 1 end, 2 threshold, 3 period, 4 read snapshot, 5 write snapshot, 6 status, 7 enables (bit0 space source, bit1 remain source). Any other read address returns 0. Status bits: bit0 space, bit1 remain, bit2 write overrun, bit3 read overrun.

Top module: `ring_ptr_tracker`

## Requirements
- R1: With length L = end − start and live offsets r (read) and w (write), avail_o is w−r when r ≤ w and L−(r−w) otherwise. avail_end_o is w−r when r ≤ w and L−r otherwise.
- R2: space_o is L−(w−r)−8 when r ≤ w and r−w−8 otherwise. space_end_o is r−w−8 when r > w, L−w when r ≤ w and r ≠ 0, and L−w−8 when r = 0.
- R3: A threshold write takes effect only when the value is strictly below L. Otherwise the old threshold is kept, as read back at address 2.
- R4: A start with bit0 = 0 (playback) sets r = 0 and w = L − period, enables only the space source, and the enables readback then shows 2'b01.
- R5: A start with bit0 = 1 (capture) sets w = 0 and r = L − period, enables only the remain source, and the enables readback then shows 2'b10.
- R6: Writing a staging register does not move the live pointer. A load strobe sets the selected live offset to (staged address − start).
- R7: A snapshot strobe stores start + live offset. The stored value does not change when the pointers move afterwards.
- R8: An advance by n moves the pointer to (offset + n) mod L, for n ≤ L.
- R9: A producer advance larger than space_o sets status bit2. A consumer advance larger than avail_o sets status bit3. The comparison uses the figures from before the advance, and irq_o is high while any status bit is set.
- R10: The space bit sets when its source is enabled and space_o ≥ threshold. The remain bit sets when its source is enabled and avail_o ≥ threshold. Each bit stays set until a one is written to it at address 9.
- R11: In one cycle, a producer advance and a consumer advance both take effect. A clear that meets a still-true set condition leaves the bit set. A load strobe overrides an advance of the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | AW | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | AW | Register read data (combinational) |
| prod_adv | input | 1 | Producer advances the write pointer this cycle |
| prod_bytes | input | AW | Producer advance in bytes |
| cons_adv | input | 1 | Consumer advances the read pointer this cycle |
| cons_bytes | input | AW | Consumer advance in bytes |
| avail_o | output | AW | Bytes waiting to be consumed |
| avail_end_o | output | AW | Waiting bytes before the physical end |
| space_o | output | AW | Free bytes, guard gap excluded |
| space_end_o | output | AW | Contiguous free bytes before the physical end |
| irq_o | output | 1 | High while any status bit is set |

## Verification
Several things can land in the same cycle: a producer advance and a consumer advance, and a status-clear write and the threshold condition that would set the same bit. The random phase fires both advances together in many cycles. Each advance is bounded by the free space and the waiting count from before that cycle, so the bench model can sum both moves and the result must show no overrun. Directed steps write the clear while free space still exceeds the threshold, where the bit must stay set. The clear is then repeated after a producer step has pushed free space below the threshold, where the bit must drop. A further step applies a load strobe and a producer advance together and expects the loaded value.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

  // Free-space guard gap in bytes; keeps a full buffer distinguishable from empty
  localparam int GUARD_BYTES = 8;

  // Write-side register addresses
  typedef enum logic [3:0] {
    WA_BASE   = 4'd0,
    WA_END    = 4'd1,
    WA_THR    = 4'd2,
    WA_PERIOD = 4'd3,
    WA_RDSTG  = 4'd4,
    WA_WRSTG  = 4'd5,
    WA_LOAD   = 4'd6,
    WA_SNAP   = 4'd7,
    WA_START  = 4'd8,
    WA_CLEAR  = 4'd9
  } wr_addr_e;

  // Read-side register addresses
  typedef enum logic [3:0] {
    RA_BASE   = 4'd0,
    RA_END    = 4'd1,
    RA_THR    = 4'd2,
    RA_PERIOD = 4'd3,
    RA_RDSNAP = 4'd4,
    RA_WRSNAP = 4'd5,
    RA_STATUS = 4'd6,
    RA_ENABLE = 4'd7
  } rd_addr_e;

  localparam logic DIR_PLAY = 1'b0;
  localparam logic DIR_CAPT = 1'b1;

  localparam int NUM_STATUS = 4;

endpackage

// File: rtl/rbt_cfg.sv
module rbt_cfg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] base,
  output logic [AW-1:0] endr,
  output logic [AW-1:0] len,
  output logic [AW-1:0] thr,
  output logic [AW-1:0] period,
  output logic [AW-1:0] rd_stage,
  output logic [AW-1:0] wr_stage,
  output logic          load_rd,
  output logic          load_wr,
  output logic          snap_rd,
  output logic          snap_wr,
  output logic          start,
  output logic          start_dir,
  output logic [rbt_pkg::NUM_STATUS-1:0] clr
);
  import rbt_pkg::*;

  logic hit_base, hit_end, hit_thr, hit_per, hit_rdstg, hit_wrstg;
  logic thr_ok;

  assign hit_base  = reg_we && (reg_addr == WA_BASE);
  assign hit_end   = reg_we && (reg_addr == WA_END);
  assign hit_thr   = reg_we && (reg_addr == WA_THR);
  assign hit_per   = reg_we && (reg_addr == WA_PERIOD);
  assign hit_rdstg = reg_we && (reg_addr == WA_RDSTG);
  assign hit_wrstg = reg_we && (reg_addr == WA_WRSTG);

  assign len    = endr - base;
  assign thr_ok = reg_wdata < len;

  // Strobes are decoded straight from the write cycle
  assign load_rd   = reg_we && (reg_addr == WA_LOAD) && reg_wdata[0];
  assign load_wr   = reg_we && (reg_addr == WA_LOAD) && reg_wdata[1];
  assign snap_rd   = reg_we && (reg_addr == WA_SNAP) && reg_wdata[0];
  assign snap_wr   = reg_we && (reg_addr == WA_SNAP) && reg_wdata[1];
  assign start     = reg_we && (reg_addr == WA_START);
  assign start_dir = reg_wdata[0];
  assign clr       = (reg_we && (reg_addr == WA_CLEAR)) ?
                     reg_wdata[NUM_STATUS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= '0;
      endr     <= '0;
      thr      <= '0;
      period   <= '0;
      rd_stage <= '0;
      wr_stage <= '0;
    end else begin
      if (hit_base)           base     <= reg_wdata;
      if (hit_end)            endr     <= reg_wdata;
      if (hit_thr && thr_ok)  thr      <= reg_wdata;
      if (hit_per)            period   <= reg_wdata;
      if (hit_rdstg)          rd_stage <= reg_wdata;
      if (hit_wrstg)          wr_stage <= reg_wdata;
    end
  end

  // R3: an out-of-range threshold write leaves the threshold untouched
  assert_thr_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_thr && !(reg_wdata < len)) |=> (thr == $past(thr)));

  // R3: the stored threshold only changes through a threshold write
  assert_thr_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_thr |=> $stable(thr));

endmodule

// File: rtl/rbt_arith.sv
module rbt_arith #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] rd_off,
  input  logic [AW-1:0] wr_off,
  output logic [AW-1:0] avail,
  output logic [AW-1:0] avail_end,
  output logic [AW-1:0] space,
  output logic [AW-1:0] space_end
);
  localparam logic [AW-1:0] GAP = AW'(rbt_pkg::GUARD_BYTES);

  function automatic logic [AW-1:0] f_avail(input logic [AW-1:0] w,
                                            input logic [AW-1:0] r,
                                            input logic [AW-1:0] l);
    if (r <= w) return w - r;
    return l - (r - w);
  endfunction

  function automatic logic [AW-1:0] f_avail_end(input logic [AW-1:0] w,
                                                input logic [AW-1:0] r,
                                                input logic [AW-1:0] l);
    if (r <= w) return w - r;
    return l - r;
  endfunction

  function automatic logic [AW-1:0] f_space(input logic [AW-1:0] w,
                                            input logic [AW-1:0] r,
                                            input logic [AW-1:0] l);
    if (r <= w) return l - (w - r) - GAP;
    return r - w - GAP;
  endfunction

  function automatic logic [AW-1:0] f_space_end(input logic [AW-1:0] w,
                                                input logic [AW-1:0] r,
                                                input logic [AW-1:0] l);
    if (r > w)       return r - w - GAP;
    if (r != '0)     return l - w;
    return l - w - GAP;
  endfunction

  assign avail     = f_avail(wr_off, rd_off, len);
  assign avail_end = f_avail_end(wr_off, rd_off, len);
  assign space     = f_space(wr_off, rd_off, len);
  assign space_end = f_space_end(wr_off, rd_off, len);

  // R2: waiting bytes plus free bytes always equal length minus the guard gap
  assert_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (avail + space) == (len - GAP));

  // R1: the contiguous part never exceeds the total waiting count
  assert_end_le_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_off < len) && (wr_off < len)) |-> (avail_end <= avail));

endmodule

// File: rtl/rbt_ptr.sv
module rbt_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] period,
  input  logic [AW-1:0] rd_stage,
  input  logic [AW-1:0] wr_stage,
  input  logic          load_rd,
  input  logic          load_wr,
  input  logic          snap_rd,
  input  logic          snap_wr,
  input  logic          start,
  input  logic          start_dir,
  input  logic          prod_adv,
  input  logic [AW-1:0] prod_bytes,
  input  logic          cons_adv,
  input  logic [AW-1:0] cons_bytes,
  input  logic [AW-1:0] avail,
  input  logic [AW-1:0] space,
  output logic [AW-1:0] rd_off,
  output logic [AW-1:0] wr_off,
  output logic [AW-1:0] rd_snap,
  output logic [AW-1:0] wr_snap,
  output logic          en_space,
  output logic          en_remain,
  output logic          wr_ovf_ev,
  output logic          rd_ovf_ev
);
  import rbt_pkg::*;

  function automatic logic [AW-1:0] f_wrap(input logic [AW-1:0] o,
                                           input logic [AW-1:0] n,
                                           input logic [AW-1:0] l);
    logic [AW:0] sum;
    sum = {1'b0, o} + {1'b0, n};
    if (sum >= {1'b0, l}) sum = sum - {1'b0, l};
    return sum[AW-1:0];
  endfunction

  logic [AW-1:0] start_far;

  assign start_far = len - period;

  // Overrun events compare against the figures from before this cycle
  assign wr_ovf_ev = prod_adv && (prod_bytes > space);
  assign rd_ovf_ev = cons_adv && (cons_bytes > avail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_off    <= '0;
      wr_off    <= '0;
      en_space  <= 1'b0;
      en_remain <= 1'b0;
    end else if (start) begin
      if (start_dir == DIR_PLAY) begin
        rd_off    <= '0;
        wr_off    <= start_far;
        en_space  <= 1'b1;
        en_remain <= 1'b0;
      end else begin
        wr_off    <= '0;
        rd_off    <= start_far;
        en_space  <= 1'b0;
        en_remain <= 1'b1;
      end
    end else begin
      if (load_rd)       rd_off <= rd_stage - base;
      else if (cons_adv) rd_off <= f_wrap(rd_off, cons_bytes, len);
      if (load_wr)       wr_off <= wr_stage - base;
      else if (prod_adv) wr_off <= f_wrap(wr_off, prod_bytes, len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_snap <= '0;
      wr_snap <= '0;
    end else begin
      if (snap_rd) rd_snap <= base + rd_off;
      if (snap_wr) wr_snap <= base + wr_off;
    end
  end

  assert_play_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_dir == DIR_PLAY) |=>
      (en_space && !en_remain && rd_off == '0 && wr_off == $past(start_far)));

  assert_cap_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_dir == DIR_CAPT) |=>
      (en_remain && !en_space && wr_off == '0 && rd_off == $past(start_far)));

  assert_stage_noload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rd && !start && !cons_adv) |=> $stable(rd_off));

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_rd |=> $stable(rd_snap));

  assert_wrap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_adv && !start && !load_wr && wr_off < len && prod_bytes <= len)
      |=> (wr_off < $past(len)));

endmodule

// File: rtl/rbt_irq.sv
module rbt_irq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_space,
  input  logic          en_remain,
  input  logic [AW-1:0] space,
  input  logic [AW-1:0] avail,
  input  logic [AW-1:0] thr,
  input  logic [rbt_pkg::NUM_STATUS-1:0] clr,
  input  logic          wr_ovf_ev,
  input  logic          rd_ovf_ev,
  output logic [rbt_pkg::NUM_STATUS-1:0] status,
  output logic          irq
);
  import rbt_pkg::*;

  logic [NUM_STATUS-1:0] hit;
  logic                  space_hit;
  logic                  remain_hit;

  assign space_hit  = en_space  && (space >= thr);
  assign remain_hit = en_remain && (avail >= thr);
  assign hit        = {rd_ovf_ev, wr_ovf_ev, remain_hit, space_hit};

  for (genvar i = 0; i < NUM_STATUS; i++) begin : g_stat
    logic st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= (st_q & ~clr[i]) | hit[i];
    end
    assign status[i] = st_q;
  end

  assign irq = |status;

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !clr[0]) |=> status[0]);

  assert_rise_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(en_remain));

  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf_ev |=> status[2]);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && space_hit) |=> status[0]);

endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  input  logic [3:0]    reg_raddr,
  output logic [AW-1:0] reg_rdata,
  input  logic          prod_adv,
  input  logic [AW-1:0] prod_bytes,
  input  logic          cons_adv,
  input  logic [AW-1:0] cons_bytes,
  output logic [AW-1:0] avail_o,
  output logic [AW-1:0] avail_end_o,
  output logic [AW-1:0] space_o,
  output logic [AW-1:0] space_end_o,
  output logic          irq_o
);
  import rbt_pkg::*;

  logic [AW-1:0] base, endr, len, thr, period, rd_stage, wr_stage;
  logic          load_rd, load_wr, snap_rd, snap_wr, start, start_dir;
  logic [NUM_STATUS-1:0] clr, status;
  logic [AW-1:0] rd_off, wr_off, rd_snap, wr_snap;
  logic          en_space, en_remain, wr_ovf_ev, rd_ovf_ev;

  rbt_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .base(base), .endr(endr), .len(len), .thr(thr), .period(period),
    .rd_stage(rd_stage), .wr_stage(wr_stage),
    .load_rd(load_rd), .load_wr(load_wr),
    .snap_rd(snap_rd), .snap_wr(snap_wr),
    .start(start), .start_dir(start_dir), .clr(clr)
  );

  rbt_arith #(.AW(AW)) u_arith (
    .clk(clk), .rst_n(rst_n),
    .len(len), .rd_off(rd_off), .wr_off(wr_off),
    .avail(avail_o), .avail_end(avail_end_o),
    .space(space_o), .space_end(space_end_o)
  );

  rbt_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base(base), .len(len), .period(period),
    .rd_stage(rd_stage), .wr_stage(wr_stage),
    .load_rd(load_rd), .load_wr(load_wr),
    .snap_rd(snap_rd), .snap_wr(snap_wr),
    .start(start), .start_dir(start_dir),
    .prod_adv(prod_adv), .prod_bytes(prod_bytes),
    .cons_adv(cons_adv), .cons_bytes(cons_bytes),
    .avail(avail_o), .space(space_o),
    .rd_off(rd_off), .wr_off(wr_off),
    .rd_snap(rd_snap), .wr_snap(wr_snap),
    .en_space(en_space), .en_remain(en_remain),
    .wr_ovf_ev(wr_ovf_ev), .rd_ovf_ev(rd_ovf_ev)
  );

  rbt_irq #(.AW(AW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_space(en_space), .en_remain(en_remain),
    .space(space_o), .avail(avail_o), .thr(thr),
    .clr(clr), .wr_ovf_ev(wr_ovf_ev), .rd_ovf_ev(rd_ovf_ev),
    .status(status), .irq(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      RA_BASE:   reg_rdata = base;
      RA_END:    reg_rdata = endr;
      RA_THR:    reg_rdata = thr;
      RA_PERIOD: reg_rdata = period;
      RA_RDSNAP: reg_rdata = rd_snap;
      RA_WRSNAP: reg_rdata = wr_snap;
      RA_STATUS: reg_rdata = {{(AW-NUM_STATUS){1'b0}}, status};
      RA_ENABLE: reg_rdata = {{(AW-2){1'b0}}, en_remain, en_space};
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/test_ring_ptr_tracker.sv
module test_ring_ptr_tracker;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [3:0]    reg_raddr = '0;
  logic [AW-1:0] reg_rdata;
  logic          prod_adv = 1'b0;
  logic [AW-1:0] prod_bytes = '0;
  logic          cons_adv = 1'b0;
  logic [AW-1:0] cons_bytes = '0;
  logic [AW-1:0] avail_o, avail_end_o, space_o, space_end_o;
  logic          irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  int m_base, m_len, m_rd, m_wr;

  always #2 clk = ~clk;

  ring_ptr_tracker #(.AW(AW)) i_ring_ptr_tracker (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .prod_adv(prod_adv), .prod_bytes(prod_bytes),
    .cons_adv(cons_adv), .cons_bytes(cons_bytes),
    .avail_o(avail_o), .avail_end_o(avail_end_o),
    .space_o(space_o), .space_end_o(space_end_o),
    .irq_o(irq_o)
  );

  // Occupancy restated: waiting bytes as a modular difference
  function automatic int e_avail();
    return (m_wr - m_rd + m_len) % m_len;
  endfunction
  function automatic int e_space();
    return m_len - 8 - e_avail();
  endfunction
  function automatic int e_avail_end();
    return (m_rd > m_wr) ? (m_len - m_rd) : e_avail();
  endfunction
  function automatic int e_space_end();
    if (m_rd > m_wr) return e_space();
    return (m_rd == 0) ? (m_len - m_wr - 8) : (m_len - m_wr);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = AW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic adv(bit p, int pb, bit c, int cb);
    @(negedge clk);
    prod_adv = p; prod_bytes = AW'(pb);
    cons_adv = c; cons_bytes = AW'(cb);
    @(negedge clk);
    prod_adv = 1'b0; cons_adv = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_raddr = 4'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic check_counts(string ctx);
    chk({ctx, " R1 avail"}, int'(avail_o), e_avail());
    chk({ctx, " R1 avail_end"}, int'(avail_end_o), e_avail_end());
    chk({ctx, " R2 space"}, int'(space_o), e_space());
    chk({ctx, " R2 space_end"}, int'(space_end_o), e_space_end());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5A17C3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("reset avail R1", int'(avail_o), 0);
    chk("reset irq R10", int'(irq_o), 0);
    rd(6, v); chk("reset status R10", v, 0);

    // R3: zero length rejects any threshold
    wr(2, 5);
    rd(2, v); chk("thr with zero length R3", v, 0);

    m_base = 'h100; m_len = 256;
    wr(0, 'h100); wr(1, 'h200); wr(3, 64);
    wr(2, 300); rd(2, v); chk("thr 300 rejected R3", v, 0);
    wr(2, 255); rd(2, v); chk("thr 255 accepted R3", v, 255);
    wr(2, 256); rd(2, v); chk("thr 256 rejected R3", v, 255);
    rd(7, v); chk("enables before start R4", v, 0);

    // R4: playback start
    wr(8, 0);
    m_rd = 0; m_wr = 192;
    check_counts("play start R4");
    rd(7, v); chk("play enables R4", v, 1);
    rd(6, v); chk("no space irq above thr R10", v & 1, 0);

    // R10 / R11: threshold event, sticky and set-over-clear
    wr(2, 40);
    @(negedge clk);
    rd(6, v); chk("space bit set R10", v & 1, 1);
    chk("irq high R10", int'(irq_o), 1);
    wr(9, 1);
    rd(6, v); chk("clear loses to live set R11", v & 1, 1);
    adv(1, 32, 0, 0); m_wr = 224;
    check_counts("after produce");
    rd(6, v); chk("bit sticky below thr R10", v & 1, 1);
    wr(9, 1);
    rd(6, v); chk("clear drops bit R10", v & 1, 0);
    chk("irq low after clear R10", int'(irq_o), 0);

    // R7: snapshots
    wr(7, 3);
    rd(4, v); chk("rd snapshot R7", v, 'h100);
    rd(5, v); chk("wr snapshot R7", v, 'h1E0);
    adv(0, 0, 1, 16); m_rd = 16;
    check_counts("after consume");
    rd(4, v); chk("rd snapshot holds R7", v, 'h100);

    // R6: staging alone does nothing, load commits
    wr(4, 'h1F0); wr(5, 'h1F8);
    check_counts("staging no move R6");
    wr(6, 3); m_rd = 240; m_wr = 248;
    check_counts("after load R6");
    chk("load avail R6", int'(avail_o), 8);

    // R8: wrap
    adv(1, 20, 0, 0); m_wr = 12;
    check_counts("wrap R8");
    chk("wrap space_end R8", int'(space_end_o), 220);

    // R9: overruns
    wr(9, 15);
    adv(1, 230, 0, 0); m_wr = (12 + 230) % 256;
    rd(6, v); chk("write overrun flag R9", (v >> 2) & 1, 1);
    chk("irq on overrun R9", int'(irq_o), 1);
    wr(9, 4);
    rd(6, v); chk("write overrun cleared R9", (v >> 2) & 1, 0);
    wr(4, 'h100); wr(5, 'h100 + 100); wr(6, 3);
    m_rd = 0; m_wr = 100;
    check_counts("reload");
    adv(0, 0, 1, 150); m_rd = 150;
    rd(6, v); chk("read overrun flag R9", (v >> 3) & 1, 1);
    wr(9, 15);

    // random phase, producer and consumer often in the same cycle (R11)
    for (int i = 0; i < 400; i++) begin
      int sp, cn, pb, cb;
      bit pe, ce;
      sp = e_space(); cn = e_avail();
      pe = 1'($urandom % 2); ce = 1'($urandom % 2);
      pb = int'($urandom % (sp + 1));
      cb = int'($urandom % (cn + 1));
      adv(pe, pb, ce, cb);
      if (pe) m_wr = (m_wr + pb) % m_len;
      if (ce) m_rd = (m_rd + cb) % m_len;
      check_counts($sformatf("random %0d R8 R11", i));
    end
    rd(6, v); chk("no false overrun R9", (v >> 2) & 3, 0);

    // R5: capture start
    wr(8, 1);
    m_wr = 0; m_rd = 192;
    check_counts("cap start R5");
    rd(7, v); chk("cap enables R5", v, 2);
    wr(9, 15);
    rd(6, v); chk("remain bit only R10", v, 2);

    // R11: both advances in one cycle
    adv(1, 16, 1, 32); m_wr = 16; m_rd = 224;
    check_counts("dual advance R11");
    chk("dual advance avail R11", int'(avail_o), 48);

    // R11: load beats advance on the same pointer
    wr(5, 'h150);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = AW'(2);
    prod_adv = 1'b1; prod_bytes = AW'(8);
    @(negedge clk);
    reg_we = 1'b0; prod_adv = 1'b0;
    m_wr = 'h50;
    check_counts("load over advance R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule